// File: doc/BRIEF.md
# Xorshift Shift-Triple Period Checker

This block decides whether one shift triple (a, b, c) turns an 8-bit or 16-bit xorshift generator into a full-period sequence. A host presents the three shift amounts and a width select, then pulses `start`. The block captures those inputs, loads its generator state with the value 1 and advances the state by one xorshift step per clock. It counts the steps until the state comes back to 1, turns into zero, or the count reaches the largest possible period.

When the run ends the block pulses `done` for one cycle. In that same cycle it presents the measured period and a pass flag. A triple passes only when the sequence returns to the seed after exactly 2^n - 1 steps, which is 255 for the 8-bit width and 65535 for the 16-bit width. Each run checks one triple. The results stay on the outputs until the next run finishes, so a sweep over many triples can be driven from outside, one triple at a time.

Top module: `xsPeriodCheck`

## Requirements
- R1: A `start` pulse while no run is active captures `shA`, `shB`, `shC` and `wide` and loads the state with 1. The first step happens on the next clock edge, and one step happens on every edge after that until the run ends.
- R2: One step computes s1 = s ^ (s << a), then s2 = s1 ^ (s1 >> b), then s3 = s2 ^ (s2 << c). The arithmetic is limited to the selected width: the low 8 bits when `wide`=0 and all 16 bits when `wide`=1. A shift amount of the width or more contributes nothing, so (9,9,9) at 8 bits returns to 1 after one step.
- R3: The run ends on the step whose result equals 1. `period` is the number of steps taken. `pass`=1 exactly when `period` equals 255 (`wide`=0) or 65535 (`wide`=1).
- R4: If a step produces the zero state, the run ends on that step with `pass`=0, and `period` counts that step. Any shift amount of 0 therefore ends the run with `period`=1.
- R5: No run takes more than 2^n - 1 steps. If the step count reaches that limit without a return to 1, the run ends with `pass`=0 and `period`=2^n - 1.
- R6: `done` is high for exactly one cycle, on the cycle after the edge of the final step, which is N cycles after the edge that samples `start` for a period of N. `pass` and `period` change only together with `done` and hold their values afterwards.
- R7: A `start` pulse during an active run is ignored. The run in progress keeps the triple and width it captured.
- R8: These 8-bit triples pass: (1,1,2), (3,5,7), (7,5,3), (7,7,1). These 16-bit triples pass: (13,9,7), (1,1,14).
- R9: The triple (1,1,1) at 8 bits is reported as a fail with a period below 255.
- R10: After reset, `done`, `pass` and `period` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run when no run is active |
| shA | input | 4 | First left-shift amount |
| shB | input | 4 | Right-shift amount |
| shC | input | 4 | Second left-shift amount |
| wide | input | 1 | 0 selects 8-bit width, 1 selects 16-bit width |
| done | output | 1 | One-cycle pulse when a run ends |
| pass | output | 1 | Set when the last run had full period |
| period | output | 16 | Step count of the last run |

## Verification
The assertions check on every cycle that the following hold:
- The state is never zero while a run is stepping.
- The step count stays below the width's limit.
- The captured triple does not change during a run.
- `done` never lasts two cycles.
- `pass` and `period` only move together with `done`.
- A passing result always shows 255 or 65535.

Only the bench's scenarios can show the rest: that the step arithmetic is right, that particular triples measure the correct period, that the latency from `start` to `done` equals the period, and that a start during a run leaves the result unchanged. The bench covers these with a sweep over many 8-bit triples, compared against an arithmetic model, plus the named 16-bit full-period cases.

// File: rtl/xsPkg.sv
package xsPkg;
  typedef struct packed {
    logic load;    // capture triple, seed state
    logic step;    // advance state and count
    logic finish;  // register result
  } xsStrobes_t;
endpackage

// File: rtl/xsDatapath.sv
module xsDatapath
  import xsPkg::*;
#(
  parameter int W      = 16,
  parameter int NARROW = 8,
  parameter int SHW    = $clog2(W)
) (
  input  logic           clk,
  input  logic           rstN,
  input  xsStrobes_t     strb,
  input  logic [SHW-1:0] shAIn,
  input  logic [SHW-1:0] shBIn,
  input  logic [SHW-1:0] shCIn,
  input  logic           wideIn,
  output logic           endSeed,
  output logic           endZero,
  output logic           endMax,
  output logic           passOut,
  output logic [W-1:0]   periodOut
);
  localparam logic [W-1:0] WIDEMASK   = '1;
  localparam logic [W-1:0] NARROWMASK = {{(W-NARROW){1'b0}}, {NARROW{1'b1}}};
  localparam logic [W-1:0] SEED       = {{(W-1){1'b0}}, 1'b1};
  localparam int           NSTAGE     = 3;

  logic [SHW-1:0] shQ [NSTAGE];
  logic           wideQ;
  logic [W-1:0]   stateQ, stepCnt, cntNext, limit, mask;
  logic [W-1:0]   stg [NSTAGE+1];

  assign mask  = wideQ ? WIDEMASK : NARROWMASK;
  assign limit = mask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shQ[0] <= '0; shQ[1] <= '0; shQ[2] <= '0;
      wideQ  <= 1'b0;
    end else if (strb.load) begin
      shQ[0] <= shAIn; shQ[1] <= shBIn; shQ[2] <= shCIn;
      wideQ  <= wideIn;
    end
  end

  assign stg[0] = stateQ;
  for (genvar k = 0; k < NSTAGE; k++) begin : gStage
    if (k == 1) begin : gRight
      assign stg[k+1] = stg[k] ^ (stg[k] >> shQ[k]);
    end else begin : gLeft
      assign stg[k+1] = stg[k] ^ ((stg[k] << shQ[k]) & mask);
    end
  end

  assign cntNext = stepCnt + 1'b1;
  assign endSeed = (stg[NSTAGE] == SEED);
  assign endZero = (stg[NSTAGE] == '0);
  assign endMax  = (cntNext == limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= SEED;
      stepCnt <= '0;
    end else if (strb.load) begin
      stateQ  <= SEED;
      stepCnt <= '0;
    end else if (strb.step) begin
      stateQ  <= stg[NSTAGE];
      stepCnt <= cntNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      passOut   <= 1'b0;
      periodOut <= '0;
    end else if (strb.finish) begin
      passOut   <= endSeed && endMax;
      periodOut <= cntNext;
    end
  end

  assert_nonzero_state_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> stateQ != '0);
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |-> stepCnt < limit);
  assert_triple_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && $past(strb.step)) |->
      ($stable(shQ[0]) && $stable(shQ[1]) && $stable(shQ[2]) && $stable(wideQ)));
endmodule

// File: rtl/xsControl.sv
module xsControl
  import xsPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       endSeed,
  input  logic       endZero,
  input  logic       endMax,
  output xsStrobes_t strb,
  output logic       doneOut
);
  typedef enum logic {IDLE, RUN} xsMode_t;
  xsMode_t modeQ;

  always_comb begin
    strb.load   = (modeQ == IDLE) && start;
    strb.step   = (modeQ == RUN);
    strb.finish = (modeQ == RUN) && (endSeed || endZero || endMax);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ   <= IDLE;
      doneOut <= 1'b0;
    end else begin
      doneOut <= strb.finish;
      if (strb.load)        modeQ <= RUN;
      else if (strb.finish) modeQ <= IDLE;
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    doneOut |=> !doneOut);
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == RUN && start && !strb.finish) |=> modeQ == RUN);
endmodule

// File: rtl/xsPeriodCheck.sv
module xsPeriodCheck
  import xsPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [3:0]  shA,
  input  logic [3:0]  shB,
  input  logic [3:0]  shC,
  input  logic        wide,
  output logic        done,
  output logic        pass,
  output logic [15:0] period
);
  localparam int W      = 16;
  localparam int NARROW = 8;
  localparam logic [W-1:0] FULLMAX   = '1;
  localparam logic [W-1:0] NARROWMAX = {{(W-NARROW){1'b0}}, {NARROW{1'b1}}};

  xsStrobes_t strb;
  logic endSeed, endZero, endMax;

  xsControl uCtl (
    .clk(clk), .rstN(rstN), .start(start),
    .endSeed(endSeed), .endZero(endZero), .endMax(endMax),
    .strb(strb), .doneOut(done)
  );

  xsDatapath #(.W(W), .NARROW(NARROW), .SHW(4)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .shAIn(shA), .shBIn(shB), .shCIn(shC), .wideIn(wide),
    .endSeed(endSeed), .endZero(endZero), .endMax(endMax),
    .passOut(pass), .periodOut(period)
  );

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(pass) && $stable(period)));
  assert_pass_full_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && pass) |-> (period == NARROWMAX || period == FULLMAX));
endmodule

// File: tb/sim_xsPeriodCheck.sv
module sim_xsPeriodCheck;
  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, wide = 1'b0;
  logic [3:0] shA = '0, shB = '0, shC = '0;
  logic done, pass;
  logic [15:0] period;
  int checkN = 0, failN = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  xsPeriodCheck u0 (.clk(clk), .rstN(rstN), .start(start), .shA(shA), .shB(shB),
    .shC(shC), .wide(wide), .done(done), .pass(pass), .period(period));

  function automatic int modelRun(int a, int b, int c, bit w, output bit ok);
    int m = w ? 65535 : 255;
    int s = 1;
    for (int n = 1; n <= m; n++) begin
      int t = s ^ ((s << a) & m);
      t = t ^ (t >> b);
      t = t ^ ((t << c) & m);
      if (t == 1) begin ok = (n == m); return n; end
      if (t == 0) begin ok = 0; return n; end
      s = t;
    end
    ok = 0;
    return m;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checkN++;
    if (!ok) begin
      failN++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Starts one run and waits for done; pokeAt>0 pulses start mid-run with another triple.
  task automatic runTriple(input int a, b, c, input bit w, input string req,
                           input int pokeAt, output int gotP, output bit gotOk);
    bit expOk;
    int expP = modelRun(a, b, c, w, expOk);
    int cnt = 0;
    @(negedge clk);
    shA = 4'(a); shB = 4'(b); shC = 4'(c); wide = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    forever begin
      @(negedge clk);
      cnt++;
      if (pokeAt > 0 && cnt == pokeAt) begin
        shA = 4'd7; shB = 4'd7; shC = 4'd1; wide = ~w; start = 1'b1;
      end else start = 1'b0;
      if (done || cnt > 70000) break;
    end
    start = 1'b0;
    gotP = int'(period); gotOk = pass;
    check(int'(period) == expP, req, $sformatf("period (%0d,%0d,%0d) w=%0d", a, b, c, w), int'(period), expP);
    check(pass == expOk, req, $sformatf("pass (%0d,%0d,%0d) w=%0d", a, b, c, w), int'(pass), int'(expOk));
    check(cnt == expP, "R6", $sformatf("latency (%0d,%0d,%0d)", a, b, c), cnt, expP);
    check(int'(period) <= (w ? 65535 : 255), "R5", "period bound", int'(period), w ? 65535 : 255);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!finished) begin
      failN++; checkN++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checkN - failN, checkN);
      $finish;
    end
  end

  initial begin
    int p; bit ok;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!done && !pass && period == 0, "R10", "reset outputs", int'(period), 0);
    rstN = 1'b1;
    // R8 named 8-bit full-period triples
    runTriple(1, 1, 2, 0, "R8", 0, p, ok); check(ok && p == 255, "R8", "(1,1,2)", p, 255);
    runTriple(3, 5, 7, 0, "R8", 0, p, ok); check(ok && p == 255, "R8", "(3,5,7)", p, 255);
    runTriple(7, 5, 3, 0, "R8", 0, p, ok); check(ok && p == 255, "R8", "(7,5,3)", p, 255);
    runTriple(7, 7, 1, 0, "R8", 0, p, ok); check(ok && p == 255, "R8", "(7,7,1)", p, 255);
    // R6 result holds after done
    repeat (6) @(negedge clk);
    check(!done && pass && period == 255, "R6", "hold after done", int'(period), 255);
    // R9 known failing triple
    runTriple(1, 1, 1, 0, "R9", 0, p, ok); check(!ok && p < 255, "R9", "(1,1,1) fail short", p, 254);
    // R4 zero state
    runTriple(0, 3, 5, 0, "R4", 0, p, ok); check(!ok && p == 1, "R4", "a=0 zero", p, 1);
    runTriple(4, 0, 2, 1, "R4", 0, p, ok); check(!ok && p == 1, "R4", "b=0 zero wide", p, 1);
    // R2 shift beyond width contributes nothing
    runTriple(9, 9, 9, 0, "R2", 0, p, ok); check(!ok && p == 1, "R2", "(9,9,9) identity", p, 1);
    // R7 start while running ignored; R1 capture
    runTriple(3, 5, 7, 0, "R7", 10, p, ok); check(ok && p == 255, "R7", "poke mid-run", p, 255);
    runTriple(2, 3, 1, 0, "R1", 3, p, ok);
    // R3 sweep over 8-bit triples against the model
    for (int a = 1; a <= 7; a++)
      for (int bi = 0; bi < 3; bi++)
        for (int c = 1; c <= 7; c++)
          runTriple(a, (bi == 0) ? 1 : (bi == 1 ? 5 : 7), c, 0, "R3", 0, p, ok);
    // R8 16-bit samples
    runTriple(13, 9, 7, 1, "R8", 0, p, ok); check(ok && p == 65535, "R8", "(13,9,7) wide", p, 65535);
    runTriple(1, 1, 14, 1, "R8", 0, p, ok); check(ok && p == 65535, "R8", "(1,1,14) wide", p, 65535);
    finished = 1;
    $display("%0d/%0d checks passed", checkN - failN, checkN);
    $finish;
  end
endmodule